// File: doc/BRIEF.md
# MDIO Management Access Controller

This block is a clause 22 MDIO master. Software reaches it through two 32-bit registers. The control register holds an enable bit and a clock divider. The user-access register starts and describes a single PHY register access.

To run an access, software first enables the controller and picks a divider. It then writes the user-access register with the GO bit set, the read/write select, the PHY and register addresses, and, for a write, the data. The controller derives MDC from the system clock and shifts the whole frame on MDIO: preamble, start, opcode, addresses, turnaround and data. On a read it releases the line and captures the PHY's acknowledge and data. When the frame ends it clears GO.

Software polls GO, or the idle flag in the control register, before it starts the next access. It reads the result from the low half of the user-access register. That data is valid only when the acknowledge bit is set.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the control register reads 0x8000_0000 (idle set, disabled, divider 0), the user-access register reads 0, MDC is low and the MDIO output enable is low.
- R2: A user-access write with GO (bit 31) set while the controller is enabled starts one frame. GO reads 1 until the frame ends and clears exactly 128×(divider+1) clock cycles after the write edge. Each MDC half period lasts divider+1 clocks.
- R3: The frame is 64 bits long and is driven most significant bit first, with each bit stable at the MDC rising edge. It consists of 32 ones, start bits 01, an opcode (01 for write, 10 for read), the 5-bit PHY address, the 5-bit register address, turnaround 10 (write only) and 16 data bits.
- R4: On a read, the output enable is low for the last 18 bit times (turnaround and data). The 16 bits sampled on the MDC rising edges, first-received bit in position 15, land in user-access bits 15:0 when GO clears.
- R5: On a read, a low level on MDIO at the second turnaround bit sets the acknowledge bit (bit 29) when GO clears. A high level leaves it 0. A write leaves it 0.
- R6: A user-access write while GO is 1 is ignored. No field changes and no second frame starts.
- R7: While the enable bit (control bit 30) is 0, the GO bit of a user-access write is ignored and GO stays 0.
- R8: Control bit 31 reads 1 exactly when no frame is in progress. The low DIV_W bits of the control register hold the divider.
- R9: When no frame is in progress, MDC stays low and the MDIO output enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 user access |
| bus_wdata | input | 32 | Register write data |
| ctrl_rdata | output | 32 | Control register contents |
| user_rdata | output | 32 | User-access register contents |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
GO is due to clear 128×(divider+1) clock edges after the edge that takes the starting write. The bench counts edges, sampling 1 ns after each one, and compares that count against the expected value. Frame bits and the output enable are recorded at every MDC rising edge, while the PHY model changes MDIO 1 ns after that edge, so each sampled value is stable. Read data and the acknowledge bit are checked once GO has cleared, because both change on that same edge.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PRE_BITS   = 32;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TA_POS     = PRE_BITS + 4 + 2 * ADDR_W;
  localparam int DATA_POS   = TA_POS + 2;

  // user-access register field positions
  localparam int U_GO   = 31;
  localparam int U_WR   = 30;
  localparam int U_ACK  = 29;
  localparam int U_REG  = 21;
  localparam int U_PHY  = 16;
  // control register field positions
  localparam int C_IDLE = 31;
  localparam int C_EN   = 30;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             hit;

  assign hit  = run && (cnt == div);
  assign rise = hit && !mdc;
  assign fall = hit && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (hit) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ack
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      bitcnt;
  logic                  active;
  logic                  rd_mode;
  mdio_op_e              op;
  logic [1:0]            ta;
  logic [DATA_W-1:0]     dat;

  assign op    = is_write ? OP_WRITE : OP_READ;
  assign ta    = is_write ? 2'b10 : 2'b11;
  assign dat   = is_write ? wdata : {DATA_W{1'b1}};
  assign frame = {{PRE_BITS{1'b1}}, 2'b01, op, phy_addr, reg_addr, ta, dat};

  assign mdio_o = shreg[FRAME_BITS-1];
  assign done   = active && fall && (bitcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bitcnt  <= '0;
      active  <= 1'b0;
      rd_mode <= 1'b0;
      mdio_oe <= 1'b0;
      rd_data <= '0;
      rd_ack  <= 1'b0;
    end else if (start) begin
      shreg   <= frame;
      bitcnt  <= '0;
      active  <= 1'b1;
      rd_mode <= !is_write;
      mdio_oe <= 1'b1;
      rd_data <= '0;
      rd_ack  <= 1'b0;
    end else if (active) begin
      if (rise && rd_mode) begin
        if (int'(bitcnt) == TA_POS + 1)
          rd_ack <= ~mdio_i;
        if (int'(bitcnt) >= DATA_POS)
          rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      end
      if (fall) begin
        if (bitcnt == LAST) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
          shreg   <= '0;
        end else begin
          bitcnt <= bitcnt + 1'b1;
          shreg  <= {shreg[FRAME_BITS-2:0], 1'b1};
          if (rd_mode && (int'(bitcnt) + 1 >= TA_POS))
            mdio_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_sel,
  input  logic [31:0] bus_wdata,
  output logic [31:0] ctrl_rdata,
  output logic [31:0] user_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int PAD_W = 30 - DIV_W;

  logic              en;
  logic [DIV_W-1:0]  div;
  logic              go;
  logic              wr_sel;
  logic              ack;
  logic [ADDR_W-1:0] phy_addr;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] data;
  logic              user_wr;
  logic              start;
  logic              rise;
  logic              fall;
  logic              done;
  logic [DATA_W-1:0] rd_data;
  logic              rd_ack;

  assign user_wr = bus_wr && bus_sel && !go;
  assign start   = user_wr && bus_wdata[U_GO] && en;

  assign ctrl_rdata = {~go, en, {PAD_W{1'b0}}, div};
  assign user_rdata = {go, wr_sel, ack, 3'b000, reg_addr, phy_addr, data};

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      div      <= '0;
      go       <= 1'b0;
      wr_sel   <= 1'b0;
      ack      <= 1'b0;
      phy_addr <= '0;
      reg_addr <= '0;
      data     <= '0;
    end else begin
      if (bus_wr && !bus_sel) begin
        en  <= bus_wdata[C_EN];
        div <= bus_wdata[DIV_W-1:0];
      end
      if (user_wr) begin
        wr_sel   <= bus_wdata[U_WR];
        reg_addr <= bus_wdata[U_REG +: ADDR_W];
        phy_addr <= bus_wdata[U_PHY +: ADDR_W];
        data     <= bus_wdata[DATA_W-1:0];
        ack      <= 1'b0;
        if (start)
          go <= 1'b1;
      end
      if (done) begin
        go <= 1'b0;
        if (!wr_sel) begin
          data <= rd_data;
          ack  <= rd_ack;
        end
      end
    end
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk  (clk),
    .rst  (rst),
    .run  (go),
    .div  (div),
    .mdc  (mdc),
    .rise (rise),
    .fall (fall)
  );

  mdio_frame_eng u_eng (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .is_write (bus_wdata[U_WR]),
    .phy_addr (bus_wdata[U_PHY +: ADDR_W]),
    .reg_addr (bus_wdata[U_REG +: ADDR_W]),
    .wdata    (bus_wdata[DATA_W-1:0]),
    .rise     (rise),
    .fall     (fall),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .rd_data  (rd_data),
    .rd_ack   (rd_ack)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic        bus_sel,
  input logic [31:0] ctrl_rdata,
  input logic [31:0] user_rdata,
  input logic        mdc,
  input logic        mdio_oe
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !user_rdata[31] |-> (!mdc && !mdio_oe)); // R9

  AST_END_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(user_rdata[31]) |-> $fell(mdc)); // R2

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (user_rdata[31] && bus_wr && bus_sel) |=> (user_rdata[25:16] == $past(user_rdata[25:16]))); // R6

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_rdata[30] && !user_rdata[31]) |=> !user_rdata[31]); // R7

  AST_ACK_AT_READ_END: assert property (@(posedge clk) disable iff (rst)
    $rose(user_rdata[29]) |-> ($fell(user_rdata[31]) && !user_rdata[30])); // R5

  AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (rst)
    ctrl_rdata[31] != user_rdata[31]); // R8
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_sel    (bus_sel),
  .ctrl_rdata (ctrl_rdata),
  .user_rdata (user_rdata),
  .mdc        (mdc),
  .mdio_oe    (mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_test.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic [31:0] user_rdata;
  logic        mdc;
  logic        mdio_i;
  logic        mdio_o;
  logic        mdio_oe;

  int unsigned checks = 0;
  int unsigned fails  = 0;

  logic [63:0] cap_o;
  logic [63:0] cap_oe;
  int          rcount = 0;
  logic        phy_ack_low = 1'b1;
  logic [15:0] phy_data = '0;

  always #2.5 clk = ~clk;

  mdio_mgmt_ctrl uut (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_sel    (bus_sel),
    .bus_wdata  (bus_wdata),
    .ctrl_rdata (ctrl_rdata),
    .user_rdata (user_rdata),
    .mdc        (mdc),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );

  // PHY model: bit index equals MDC rising edges seen so far
  always_comb begin
    if (rcount == 47)
      mdio_i = phy_ack_low ? 1'b0 : 1'b1;
    else if (rcount >= 48 && rcount <= 63)
      mdio_i = phy_data[63 - rcount];
    else
      mdio_i = 1'b1;
  end

  always @(posedge mdc) begin
    if (rcount < 64) begin
      cap_o[63 - rcount]  = mdio_o;
      cap_oe[63 - rcount] = mdio_oe;
    end
    #1 rcount = rcount + 1;
  end

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    report();
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  function automatic logic [31:0] user_word(logic go, logic w, logic [4:0] p,
                                            logic [4:0] r, logic [15:0] d);
    return {go, w, 3'b000, 1'b0, r, p, d};
  endfunction

  function automatic logic [63:0] write_frame(logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  function automatic logic [45:0] read_head(logic [4:0] p, logic [4:0] r);
    return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
  endfunction

  task automatic run_txn(input logic w, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input int dv, input logic ackl,
                         input logic [15:0] pd, input bit busy_poke);
    int n;
    logic [31:0] u;
    bus_write(1'b0, 32'h4000_0000 | 32'(dv));
    phy_ack_low = ackl;
    phy_data    = pd;
    rcount      = 0;
    cap_o       = '0;
    cap_oe      = '0;
    bus_write(1'b1, user_word(1'b1, w, p, r, d));
    n = 0;
    while (n < 5000) begin
      @(posedge clk);
      #1;
      n = n + 1;
      if (busy_poke && n == 10) begin
        bus_wr = 1'b1; bus_sel = 1'b1;
        bus_wdata = user_word(1'b1, ~w, ~p, ~r, ~d);
      end
      if (busy_poke && n == 11) bus_wr = 1'b0;
      if (n == 5) chk("R8 idle flag low while busy", 64'(ctrl_rdata[31]), 64'd0);
      if (!user_rdata[31]) break;
    end
    chk("R2 completion cycles", 64'(n), 64'(128 * (dv + 1)));
    chk("R8 idle flag after frame", 64'(ctrl_rdata[31]), 64'd1);
    chk("R9 mdc/oe quiet after frame", {62'd0, mdc, mdio_oe}, 64'd0);
    u = user_rdata;
    if (busy_poke)
      chk("R6 fields kept after busy write", 64'(u[25:16]), 64'({r, p}));
    if (w) begin
      chk("R3 write frame bits", cap_o, write_frame(p, r, d));
      chk("R5 ack stays 0 on write", 64'(u[29]), 64'd0);
      chk("R3 write data kept", 64'(u[15:0]), 64'(d));
    end else begin
      chk("R3 read header bits", 64'(cap_o[63:18]), 64'(read_head(p, r)));
      chk("R4 oe pattern", cap_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
      chk("R4 read data", 64'(u[15:0]), 64'(pd));
      chk("R5 ack flag", 64'(u[29]), 64'(ackl));
    end
  endtask

  initial begin
    void'($urandom(32'd4021));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 ctrl after reset", 64'(ctrl_rdata), 64'h8000_0000);
    chk("R1 user after reset", 64'(user_rdata), 64'd0);
    chk("R1 mdc/oe after reset", {62'd0, mdc, mdio_oe}, 64'd0);

    // R7: GO ignored when disabled
    bus_write(1'b0, 32'h0000_0001);
    rcount = 0;
    bus_write(1'b1, user_word(1'b1, 1'b1, 5'd3, 5'd4, 16'h1234));
    repeat (30) @(posedge clk);
    #1;
    chk("R7 GO stays 0 while disabled", 64'(user_rdata[31]), 64'd0);
    chk("R8 idle while disabled", 64'(ctrl_rdata[31]), 64'd1);
    chk("R9 no mdc edges while idle", 64'(rcount), 64'd0);
    chk("R8 divider readback", 64'(ctrl_rdata[7:0]), 64'd1);

    // directed corners
    run_txn(1'b1, 5'h1F, 5'h00, 16'hA5C3, 0, 1'b1, 16'h0000, 1'b0);
    run_txn(1'b0, 5'h00, 5'h1F, 16'h0000, 0, 1'b0, 16'hBEEF, 1'b0);
    run_txn(1'b0, 5'h15, 5'h0A, 16'h0000, 2, 1'b1, 16'h8001, 1'b1);
    run_txn(1'b1, 5'h0A, 5'h15, 16'h0FF0, 5, 1'b1, 16'h0000, 1'b1);

    // random mix
    for (int i = 0; i < 16; i++) begin
      logic w;
      logic [4:0] p, r;
      logic [15:0] d, pd;
      int dv;
      logic ackl;
      w    = 1'($urandom);
      p    = 5'($urandom);
      r    = 5'($urandom);
      d    = 16'($urandom);
      pd   = 16'($urandom);
      dv   = int'($urandom % 4);
      ackl = 1'($urandom % 4 != 0);
      run_txn(w, p, r, d, dv, ackl, pd, 1'b0);
    end
    report();
  end
endmodule